// File: doc/BRIEF.md
# Pinned-Entry Translation Lookaside Buffer

This block is one side (instruction or data) of an address translation buffer that holds two kinds of entry. Pinned slots are written by software at an index it names. They stay until software rewrites or purges them, and hardware never replaces them. Cache entries are placed by hardware. A round-robin pointer walks every entry currently eligible for cache use: the dedicated cache entries, plus any pinned slot that holds no pinned translation. Empty entries are taken before live ones. A pinned insert into a slot that hardware has borrowed drops the borrowed cache translation.

Each entry holds a virtual base, a page size given as log2 of the byte count, a protection key, a physical base and a region identifier. The region identifier is fetched from the region tag input, indexed by the three most significant bits of the virtual address. A lookup compares the address bits above the page size and the region identifier. It returns hit, physical address and key one cycle later. An insert whose range meets a valid entry sets a sticky machine-check flag when either side of the overlap is pinned. Software clears the flag with a dedicated input. Purges come in two kinds: by pinned slot index, and by address range for cache entries.

Top module: `pin_tlb`

## Requirements
- R1: After reset no entry is valid, every lookup misses, and `mcheck` is 0.
- R2: A lookup presented in one cycle drives `lk_hit`, `lk_pa` and `lk_key` after the next rising edge. An entry matches when the region identifiers are equal and the address bits at and above its page size `ps` equal its base. `lk_pa` is the physical base above bit `ps` joined with the lookup address below bit `ps`.
- R3: The region identifier is `rgn_ids[r*RID_W +: RID_W]`, where r is the top three bits of the virtual address. It is stored at insert time and compared on lookup, so a changed identifier or a different region misses.
- R4: A pinned insert (`ins_pin`=1) writes exactly slot `ins_slot` and replaces whatever that slot held.
- R5: A cache insert (`ins_pin`=0) searches the eligible entries in round-robin order, starting at the pointer, which resets to 0 and then moves to one past the last victim. It takes the first empty eligible entry. If none is empty, it takes the first eligible entry.
- R6: A pinned slot changes only through a pinned insert or a slot purge addressed to it. Cache inserts never evict it.
- R7: A pinned slot without a pinned translation serves as an extra cache entry, so the buffer can hold more cache translations than there are dedicated entries.
- R8: A pinned insert into a slot borrowed by a cache translation removes that cache translation.
- R9: `mcheck` sets in the cycle an insert is accepted whose range meets another valid entry with the same region, when the new entry or the other entry is pinned. Overlap between two cache entries does not set it.
- R10: `mcheck` stays set until `mc_clr` is asserted. A new set in the same cycle wins over the clear.
- R11: A slot purge clears the pinned translation in slot `trp_slot`. A borrowed cache translation in that slot is left in place.
- R12: An address purge removes every cache entry whose range meets `tcp_va`/`tcp_ps` in the same region. Pinned entries are unaffected.
- R13: In one cycle, purges apply first and the insert second. A lookup in that cycle sees the state from before both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rgn_ids | input | 8*RID_W | Region identifier for each of the eight regions |
| lk_va | input | VA_W | Lookup virtual address |
| ins_vld | input | 1 | Insert request |
| ins_pin | input | 1 | 1: pinned slot insert, 0: cache insert |
| ins_slot | input | $clog2(N_PIN) | Pinned slot index |
| ins_va | input | VA_W | Virtual base |
| ins_ps | input | 6 | Page size, log2 bytes |
| ins_key | input | KEY_W | Protection key |
| ins_pa | input | PA_W | Physical base |
| trp_vld | input | 1 | Pinned slot purge request |
| trp_slot | input | $clog2(N_PIN) | Slot to purge |
| tcp_vld | input | 1 | Cache purge by address request |
| tcp_va | input | VA_W | Purge address |
| tcp_ps | input | 6 | Purge range size, log2 bytes |
| mc_clr | input | 1 | Clears the machine-check flag |
| lk_hit | output | 1 | Registered lookup hit |
| lk_pa | output | PA_W | Registered physical address |
| lk_key | output | KEY_W | Registered protection key |
| mcheck | output | 1 | Sticky overlap machine check |

## Verification
The bench builds the block with eight pinned slots and a single dedicated cache entry. With only one dedicated entry, the second and later cache inserts must land in borrowed pinned slots. This brings borrowing, pointer skipping past a pinned slot, and reclaim by a pinned insert within a handful of operations. It also means that a run of cache inserts exhausts the eligible entries quickly and wraps the pointer while the pinned translations must survive.

// File: rtl/pt_pkg.sv
`timescale 1ns/1ps
package pt_pkg;
  localparam int PS_W = 6;

  // mask keeping address bits at and above bit ps
  function automatic logic [63:0] hi_mask(input logic [PS_W-1:0] ps);
    return ~64'd0 << ps;
  endfunction

  // two aligned ranges meet when they agree above the larger page size
  function automatic logic ranges_meet(input logic [63:0] a, input logic [PS_W-1:0] pa,
                                       input logic [63:0] b, input logic [PS_W-1:0] pb);
    logic [PS_W-1:0] m;
    m = (pa > pb) ? pa : pb;
    return ((a ^ b) & hi_mask(m)) == 64'd0;
  endfunction

  // physical base above ps joined with the offset below ps
  function automatic logic [63:0] xlate(input logic [63:0] pbase, input logic [63:0] va,
                                        input logic [PS_W-1:0] ps);
    return (pbase & hi_mask(ps)) | (va & ~hi_mask(ps));
  endfunction
endpackage

// File: rtl/pt_entry_cmp.sv
`timescale 1ns/1ps
module pt_entry_cmp
  import pt_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int RID_W = 8
) (
  input  logic [VA_W-1:0]  e_va,
  input  logic [PS_W-1:0]  e_ps,
  input  logic [RID_W-1:0] e_rid,
  input  logic [VA_W-1:0]  q_va,
  input  logic [RID_W-1:0] q_rid,
  input  logic [VA_W-1:0]  i_va,
  input  logic [PS_W-1:0]  i_ps,
  input  logic [RID_W-1:0] i_rid,
  input  logic [VA_W-1:0]  p_va,
  input  logic [PS_W-1:0]  p_ps,
  input  logic [RID_W-1:0] p_rid,
  output logic             q_hit,
  output logic             i_hit,
  output logic             p_hit
);
  assign q_hit = (e_rid == q_rid) && ranges_meet(64'(e_va), e_ps, 64'(q_va), '0);
  assign i_hit = (e_rid == i_rid) && ranges_meet(64'(e_va), e_ps, 64'(i_va), i_ps);
  assign p_hit = (e_rid == p_rid) && ranges_meet(64'(e_va), e_ps, 64'(p_va), p_ps);
endmodule

// File: rtl/pt_victim.sv
`timescale 1ns/1ps
module pt_victim #(
  parameter int N  = 12,
  parameter int IW = 4
) (
  input  logic [N-1:0]  elig,
  input  logic [N-1:0]  free,
  input  logic [IW-1:0] ptr,
  output logic [IW-1:0] victim
);
  function automatic int wrap(input int p, input int k);
    int s;
    s = p + k;
    if (s >= N) s = s - N;
    return s;
  endfunction

  always_comb begin
    victim = '0;
    // descending scans: the last hit written is the nearest to ptr
    for (int k = N - 1; k >= 0; k--)
      if (elig[wrap(int'(ptr), k)]) victim = IW'(wrap(int'(ptr), k));
    for (int k = N - 1; k >= 0; k--)
      if (elig[wrap(int'(ptr), k)] && free[wrap(int'(ptr), k)]) victim = IW'(wrap(int'(ptr), k));
  end
endmodule

// File: rtl/pin_tlb.sv
`timescale 1ns/1ps
module pin_tlb
  import pt_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int N_PIN = 8,
  parameter int N_TC  = 4,
  parameter int RID_W = 8,
  parameter int KEY_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [8*RID_W-1:0]         rgn_ids,
  input  logic [VA_W-1:0]            lk_va,
  input  logic                       ins_vld,
  input  logic                       ins_pin,
  input  logic [$clog2(N_PIN)-1:0]   ins_slot,
  input  logic [VA_W-1:0]            ins_va,
  input  logic [5:0]                 ins_ps,
  input  logic [KEY_W-1:0]           ins_key,
  input  logic [PA_W-1:0]            ins_pa,
  input  logic                       trp_vld,
  input  logic [$clog2(N_PIN)-1:0]   trp_slot,
  input  logic                       tcp_vld,
  input  logic [VA_W-1:0]            tcp_va,
  input  logic [5:0]                 tcp_ps,
  input  logic                       mc_clr,
  output logic                       lk_hit,
  output logic [PA_W-1:0]            lk_pa,
  output logic [KEY_W-1:0]           lk_key,
  output logic                       mcheck
);
  localparam int N  = N_PIN + N_TC;
  localparam int IW = $clog2(N);
  localparam int SW = $clog2(N_PIN);

  // entry state
  logic [N-1:0]                e_vld, e_pin;
  logic [N-1:0][VA_W-1:0]      e_va;
  logic [N-1:0][PS_W-1:0]      e_ps;
  logic [N-1:0][KEY_W-1:0]     e_key;
  logic [N-1:0][PA_W-1:0]      e_pa;
  logic [N-1:0][RID_W-1:0]     e_rid;
  logic [IW-1:0]               rr_ptr;

  // named internal events
  logic [N-1:0] lk_m, ins_m, pur_m;
  logic [N-1:0] tr_kill, tc_kill, pp_vld, pp_pin, elig, clash;
  logic [IW-1:0] tc_victim, ins_tgt, lk_sel;
  logic          clash_any;
  logic [RID_W-1:0] lk_rid, ins_rid, tcp_rid;

  function automatic logic [RID_W-1:0] rid_of(input logic [VA_W-1:0] va);
    return rgn_ids[int'(va[VA_W-1 -: 3])*RID_W +: RID_W];
  endfunction

  assign lk_rid  = rid_of(lk_va);
  assign ins_rid = rid_of(ins_va);
  assign tcp_rid = rid_of(tcp_va);

  for (genvar i = 0; i < N; i++) begin : g_ent
    pt_entry_cmp #(.VA_W(VA_W), .RID_W(RID_W)) u_cmp (
      .e_va (e_va[i]), .e_ps (e_ps[i]), .e_rid(e_rid[i]),
      .q_va (lk_va),   .q_rid(lk_rid),
      .i_va (ins_va),  .i_ps (ins_ps), .i_rid(ins_rid),
      .p_va (tcp_va),  .p_ps (tcp_ps), .p_rid(tcp_rid),
      .q_hit(lk_m[i]), .i_hit(ins_m[i]), .p_hit(pur_m[i])
    );
    if (i < N_PIN) begin : g_pin
      assign tr_kill[i] = trp_vld && (trp_slot == SW'(i)) && e_pin[i];
      assign elig[i]    = ~pp_pin[i];
    end else begin : g_tc
      assign tr_kill[i] = 1'b0;
      assign elig[i]    = 1'b1;
    end
    assign tc_kill[i] = tcp_vld && e_vld[i] && !e_pin[i] && pur_m[i];
    assign pp_vld[i]  = e_vld[i] && !tr_kill[i] && !tc_kill[i];
    assign pp_pin[i]  = e_pin[i] && !tr_kill[i];
    assign clash[i]   = pp_vld[i] && ins_m[i] && (ins_tgt != IW'(i)) && (ins_pin || pp_pin[i]);
  end

  pt_victim #(.N(N), .IW(IW)) u_victim (
    .elig  (elig),
    .free  (~pp_vld),
    .ptr   (rr_ptr),
    .victim(tc_victim)
  );

  assign ins_tgt   = ins_pin ? IW'(ins_slot) : tc_victim;
  assign clash_any = |clash;

  always_comb begin
    lk_sel = '0;
    for (int i = N - 1; i >= 0; i--)
      if (e_vld[i] && lk_m[i]) lk_sel = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld  <= '0;
      e_pin  <= '0;
      e_va   <= '0;
      e_ps   <= '0;
      e_key  <= '0;
      e_pa   <= '0;
      e_rid  <= '0;
      rr_ptr <= '0;
      mcheck <= 1'b0;
      lk_hit <= 1'b0;
      lk_pa  <= '0;
      lk_key <= '0;
    end else begin
      e_vld <= pp_vld;
      e_pin <= pp_pin;
      if (ins_vld) begin
        e_vld[ins_tgt] <= 1'b1;
        e_pin[ins_tgt] <= ins_pin;
        e_va[ins_tgt]  <= ins_va;
        e_ps[ins_tgt]  <= ins_ps;
        e_key[ins_tgt] <= ins_key;
        e_pa[ins_tgt]  <= ins_pa;
        e_rid[ins_tgt] <= ins_rid;
        if (!ins_pin)
          rr_ptr <= (tc_victim == IW'(N - 1)) ? '0 : tc_victim + 1'b1;
      end
      if (ins_vld && clash_any) mcheck <= 1'b1;
      else if (mc_clr)          mcheck <= 1'b0;
      lk_hit <= |(e_vld & lk_m);
      if (|(e_vld & lk_m)) begin
        lk_pa  <= PA_W'(xlate(64'(e_pa[lk_sel]), 64'(lk_va), e_ps[lk_sel]));
        lk_key <= e_key[lk_sel];
      end else begin
        lk_pa  <= '0;
        lk_key <= '0;
      end
    end
  end
endmodule

// File: rtl/pin_tlb_chk.sv
`timescale 1ns/1ps
module pin_tlb_chk #(
  parameter int N     = 12,
  parameter int N_PIN = 8,
  parameter int VA_W  = 32,
  parameter int IW    = 4,
  parameter int SW    = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ins_vld,
  input logic                  ins_pin,
  input logic [SW-1:0]         ins_slot,
  input logic                  trp_vld,
  input logic [SW-1:0]         trp_slot,
  input logic                  mc_clr,
  input logic                  mcheck,
  input logic                  lk_hit,
  input logic [N-1:0]          e_vld,
  input logic [N-1:0]          e_pin,
  input logic [N-1:0][VA_W-1:0] e_va,
  input logic [N-1:0]          pp_vld,
  input logic [N-1:0]          pp_pin,
  input logic [N-1:0]          elig,
  input logic [IW-1:0]         tc_victim,
  input logic                  clash_any
);
  logic [SW-1:0] trp_q;
  always_ff @(posedge clk) trp_q <= trp_slot;

  // R1
  empty_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|e_vld) |=> !lk_hit);

  // R9
  mc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_vld && clash_any |=> mcheck);

  // R10
  mc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mcheck) |-> $past(mc_clr));

  // R5
  victim_unpinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_vld && !ins_pin |-> !pp_pin[tc_victim]);

  // R5
  victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_vld && !ins_pin && |(elig & ~pp_vld) |-> !pp_vld[tc_victim]);

  // R11
  trp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trp_vld && !(ins_vld && ins_pin && ins_slot == trp_slot) |=> !e_pin[trp_q]);

  for (genvar i = 0; i < N_PIN; i++) begin : g_hold
    // R6
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      e_pin[i] && !(ins_vld && ins_pin && ins_slot == SW'(i)) && !(trp_vld && trp_slot == SW'(i))
      |=> e_pin[i] && $stable(e_va[i]));
  end
endmodule

bind pin_tlb pin_tlb_chk #(.N(N), .N_PIN(N_PIN), .VA_W(VA_W), .IW(IW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .ins_pin(ins_pin), .ins_slot(ins_slot),
  .trp_vld(trp_vld), .trp_slot(trp_slot), .mc_clr(mc_clr), .mcheck(mcheck), .lk_hit(lk_hit),
  .e_vld(e_vld), .e_pin(e_pin), .e_va(e_va), .pp_vld(pp_vld), .pp_pin(pp_pin), .elig(elig),
  .tc_victim(tc_victim), .clash_any(clash_any)
);

// File: tb/pin_tlb_tb.sv
`timescale 1ns/1ps
module pin_tlb_tb;
  localparam int VA_W = 32, PA_W = 32, N_PIN = 8, N_TC = 1, RID_W = 8, KEY_W = 8;
  localparam logic [2:0] OP_LK = 3'd0, OP_TR = 3'd1, OP_TC = 3'd2, OP_PTR = 3'd3, OP_PTC = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  slot;
    logic [31:0] va;
    logic [5:0]  ps;
    logic [7:0]  key;
    logic [31:0] pa;
    logic        hit;
    logic [31:0] xpa;
    logic [7:0]  xkey;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{OP_TC,  3'd0, 32'h2000_0000, 6'd12, 8'h11, 32'h8000_0000, 1'b0, 32'h0, 8'h0, 4'd5},   // R5 -> slot 0
    '{OP_LK,  3'd0, 32'h2000_0123, 6'd0,  8'h00, 32'h0, 1'b1, 32'h8000_0123, 8'h11, 4'd2},   // R2
    '{OP_TR,  3'd3, 32'h2010_0000, 6'd16, 8'h22, 32'h9000_0000, 1'b0, 32'h0, 8'h0, 4'd4},   // R4
    '{OP_LK,  3'd0, 32'h2010_ABCD, 6'd0,  8'h00, 32'h0, 1'b1, 32'h9000_ABCD, 8'h22, 4'd4},
    '{OP_LK,  3'd0, 32'h2011_0000, 6'd0,  8'h00, 32'h0, 1'b0, 32'h0, 8'h00, 4'd2},           // R2 past page end
    '{OP_TC,  3'd0, 32'h2020_0000, 6'd12, 8'h33, 32'hA000_0000, 1'b0, 32'h0, 8'h0, 4'd7},   // R7 slot 1
    '{OP_TC,  3'd0, 32'h2030_0000, 6'd12, 8'h44, 32'hB000_0000, 1'b0, 32'h0, 8'h0, 4'd7},   // slot 2
    '{OP_TC,  3'd0, 32'h2040_0000, 6'd12, 8'h66, 32'hE000_0000, 1'b0, 32'h0, 8'h0, 4'd5},   // R5 skips pinned 3
    '{OP_LK,  3'd0, 32'h2020_0FFF, 6'd0,  8'h00, 32'h0, 1'b1, 32'hA000_0FFF, 8'h33, 4'd7},
    '{OP_LK,  3'd0, 32'h2030_0004, 6'd0,  8'h00, 32'h0, 1'b1, 32'hB000_0004, 8'h44, 4'd7},
    '{OP_LK,  3'd0, 32'h2040_0008, 6'd0,  8'h00, 32'h0, 1'b1, 32'hE000_0008, 8'h66, 4'd5},
    '{OP_LK,  3'd0, 32'h2010_0000, 6'd0,  8'h00, 32'h0, 1'b1, 32'h9000_0000, 8'h22, 4'd6},   // R6
    '{OP_TR,  3'd0, 32'h2050_0000, 6'd12, 8'h55, 32'hC000_0000, 1'b0, 32'h0, 8'h0, 4'd8},   // R8 reclaim
    '{OP_LK,  3'd0, 32'h2000_0000, 6'd0,  8'h00, 32'h0, 1'b0, 32'h0, 8'h00, 4'd8},
    '{OP_LK,  3'd0, 32'h2050_0010, 6'd0,  8'h00, 32'h0, 1'b1, 32'hC000_0010, 8'h55, 4'd8},
    '{OP_PTR, 3'd3, 32'h0, 6'd0, 8'h00, 32'h0, 1'b0, 32'h0, 8'h0, 4'd11},                      // R11
    '{OP_LK,  3'd0, 32'h2010_0100, 6'd0,  8'h00, 32'h0, 1'b0, 32'h0, 8'h00, 4'd11},
    '{OP_PTR, 3'd1, 32'h0, 6'd0, 8'h00, 32'h0, 1'b0, 32'h0, 8'h0, 4'd11},                      // borrowed slot
    '{OP_LK,  3'd0, 32'h2020_0000, 6'd0,  8'h00, 32'h0, 1'b1, 32'hA000_0000, 8'h33, 4'd11},
    '{OP_PTC, 3'd0, 32'h2020_0000, 6'd12, 8'h00, 32'h0, 1'b0, 32'h0, 8'h0, 4'd12},            // R12
    '{OP_LK,  3'd0, 32'h2020_0000, 6'd0,  8'h00, 32'h0, 1'b0, 32'h0, 8'h00, 4'd12},
    '{OP_PTC, 3'd0, 32'h2050_0000, 6'd12, 8'h00, 32'h0, 1'b0, 32'h0, 8'h0, 4'd12},
    '{OP_LK,  3'd0, 32'h2050_0010, 6'd0,  8'h00, 32'h0, 1'b1, 32'hC000_0010, 8'h55, 4'd12},
    '{OP_PTC, 3'd0, 32'h2030_0000, 6'd20, 8'h00, 32'h0, 1'b0, 32'h0, 8'h0, 4'd12},
    '{OP_LK,  3'd0, 32'h2030_0004, 6'd0,  8'h00, 32'h0, 1'b0, 32'h0, 8'h00, 4'd12},
    '{OP_LK,  3'd0, 32'h2040_0008, 6'd0,  8'h00, 32'h0, 1'b1, 32'hE000_0008, 8'h66, 4'd12}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [8*RID_W-1:0] rgn_ids;
  logic [VA_W-1:0] lk_va = '0, ins_va = '0, tcp_va = '0;
  logic ins_vld = 0, ins_pin = 0, trp_vld = 0, tcp_vld = 0, mc_clr = 0;
  logic [2:0] ins_slot = '0, trp_slot = '0;
  logic [5:0] ins_ps = '0, tcp_ps = '0;
  logic [KEY_W-1:0] ins_key = '0;
  logic [PA_W-1:0] ins_pa = '0;
  logic lk_hit, mcheck;
  logic [PA_W-1:0] lk_pa;
  logic [KEY_W-1:0] lk_key;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pin_tlb #(.VA_W(VA_W), .PA_W(PA_W), .N_PIN(N_PIN), .N_TC(N_TC), .RID_W(RID_W), .KEY_W(KEY_W)) u_dut (
    .clk, .rst_n, .rgn_ids, .lk_va, .ins_vld, .ins_pin, .ins_slot, .ins_va, .ins_ps, .ins_key,
    .ins_pa, .trp_vld, .trp_slot, .tcp_vld, .tcp_va, .tcp_ps, .mc_clr, .lk_hit, .lk_pa, .lk_key, .mcheck);

  function automatic logic [8*RID_W-1:0] base_rids();
    logic [8*RID_W-1:0] r;
    for (int i = 0; i < 8; i++) r[i*RID_W +: RID_W] = RID_W'(8'h40 + i);
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    ins_vld = 0; trp_vld = 0; tcp_vld = 0; mc_clr = 0;
  endtask

  task automatic ins(input logic pin, input logic [2:0] slot, input logic [31:0] va,
                     input logic [5:0] ps, input logic [7:0] key, input logic [31:0] pa);
    ins_vld = 1; ins_pin = pin; ins_slot = slot; ins_va = va; ins_ps = ps; ins_key = key; ins_pa = pa;
  endtask

  task automatic look(input string req, input logic [31:0] va, input logic hit,
                      input logic [31:0] pa, input logic [7:0] key);
    lk_va = va;
    step();
    chk(req, 64'(lk_hit), 64'(hit));
    if (hit) begin
      chk(req, 64'(lk_pa), 64'(pa));
      chk(req, 64'(lk_key), 64'(key));
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rgn_ids = base_rids();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    look("R1", 32'h0000_0000, 1'b0, '0, '0);
    chk("R1", 64'(mcheck), 64'd0);

    for (int v = 0; v < NV; v++) begin
      case (VECS[v].op)
        OP_LK: look($sformatf("R%0d", VECS[v].req), VECS[v].va, VECS[v].hit, VECS[v].xpa, VECS[v].xkey);
        OP_TR, OP_TC: begin
          ins(VECS[v].op == OP_TR, VECS[v].slot, VECS[v].va, VECS[v].ps, VECS[v].key, VECS[v].pa);
          step();
        end
        OP_PTR: begin trp_vld = 1; trp_slot = VECS[v].slot; step(); end
        default: begin tcp_vld = 1; tcp_va = VECS[v].va; tcp_ps = VECS[v].ps; step(); end
      endcase
    end
    chk("R9", 64'(mcheck), 64'd0);

    // R9: cache-cache overlap leaves flag clear
    ins(1'b0, 3'd0, 32'h2040_0000, 6'd16, 8'h77, 32'hF100_0000);
    step();
    chk("R9", 64'(mcheck), 64'd0);
    // R9: pinned insert meeting a cache entry sets it
    ins(1'b1, 3'd6, 32'h2040_8000, 6'd12, 8'h88, 32'hF000_0000);
    step();
    chk("R9", 64'(mcheck), 64'd1);
    step(); step();
    chk("R10", 64'(mcheck), 64'd1);
    mc_clr = 1;
    step();
    chk("R10", 64'(mcheck), 64'd0);

    // R3 region identifier
    rgn_ids[1*RID_W +: RID_W] = 8'hEE;
    look("R3", 32'h2050_0010, 1'b0, '0, '0);
    rgn_ids = base_rids();
    look("R3", 32'h6050_0010, 1'b0, '0, '0);
    look("R3", 32'h2050_0010, 1'b1, 32'hC000_0010, 8'h55);

    // R13 purge, insert and lookup in one cycle
    trp_vld = 1; trp_slot = 3'd0;
    ins(1'b1, 3'd0, 32'h2060_0000, 6'd12, 8'h99, 32'hD000_0000);
    look("R13", 32'h2050_0010, 1'b1, 32'hC000_0010, 8'h55);
    look("R13", 32'h2060_0004, 1'b1, 32'hD000_0004, 8'h99);
    look("R13", 32'h2050_0010, 1'b0, '0, '0);

    // R6 many cache inserts leave pinned slots in place
    for (int k = 0; k < 12; k++) begin
      ins(1'b0, 3'd0, 32'h4000_0000 + (k << 12), 6'd12, 8'h10, 32'h5000_0000 + (k << 12));
      step();
    end
    look("R6", 32'h2060_0004, 1'b1, 32'hD000_0004, 8'h99);
    look("R6", 32'h2040_8010, 1'b1, 32'hF000_0010, 8'h88);
    look("R7", 32'h4000_B020, 1'b1, 32'h5000_B020, 8'h10);
    chk("R6", 64'(mcheck), 64'd0);

    summary();
  end
endmodule